// File: doc/BRIEF.md
# Companion GPIO Controller

This peripheral sits on a simple synchronous register bus and holds a small bank of 16-bit control words next to a 16-line general-purpose I/O port. Software programs a direction mask and a level word. The lines driven out of the block are always the level word gated by the direction mask. Separate external input lines can also set or clear individual level bits directly.

Each write to the direction word or to the level word triggers an evaluation of the driven outputs. The evaluation compares the newly driven value with the value recorded at the previous evaluation. Every line whose value moved raises a one-clock change strobe, and the new driven word is presented beside the strobes. The recorded value is updated only by these evaluations. A level change caused by an input line therefore shows up in the strobes only at the next direction or level write.

Register selection is a combinational decode of the byte address into a named selector (`SEL_NONE`, `SEL_MODE`, `SEL_DETECT`, `SEL_STATUS`, `SEL_POWER`, `SEL_CTRL`, `SEL_IRAISE`, `SEL_IMASK`, `SEL_ISTAT`, `SEL_DIR`, `SEL_WLVL`, `SEL_RLVL`). There is no sequencing state. Each selector moves straight back to `SEL_NONE` when the address leaves its offset.

Top module: `aux_gpio_ctrl`

## Requirements
- R1: After reset, every mapped offset reads zero except the status offset 0x08, which reads 0x0002. `gpio_out`, `gpio_chg` and `gpio_chg_val` are all zero.
- R2: The plain storage words are mode 0x00, detect 0x04, control 0x10, interrupt raise 0x14, interrupt mask 0x18 and interrupt status 0x1C. Each one reads back the last 16-bit value written to it.
- R3: A write to the power word at 0x0C stores the data. When bit 7 of the data is 1, bits 15 and 6 of the stored word are also set, so the word holds data OR 0x8040.
- R4: The status word at 0x08 is read-only. Writes to 0x08 leave its read value at 0x0002.
- R5: The direction word is at 0x20. A write to either 0x24 or 0x28 stores (data AND direction) into the level word. Reads at both 0x24 and 0x28 return the level word, and a read at 0x20 returns the direction word.
- R6: `gpio_out` equals level AND direction at all times.
- R7: Every write to 0x20, 0x24 or 0x28 evaluates the outputs. In the clock cycle after the write, `gpio_chg` pulses for exactly one cycle on each bit where the new driven value differs from the value recorded at the previous evaluation. `gpio_chg_val` then holds the new driven word, and that word becomes the recorded value.
- R8: A rising or falling edge on a `gpio_in` bit sets or clears the matching level bit on the next clock. It raises no `gpio_chg` strobe.
- R9: An address that is unaligned, above 0x28, or outside the low 64-byte window is unmapped. A write to it changes nothing, and a read from it returns zero.
- R10: When an input edge and a level write land in the same cycle, the input edge decides the value of the bits it touches. The evaluation triggered by that write uses the resulting level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| gpio_in | input | 16 | External lines whose edges set or clear level bits |
| gpio_out | output | 16 | Driven lines, level AND direction |
| gpio_chg | output | 16 | One-cycle per-line change strobes |
| gpio_chg_val | output | 16 | Driven word captured at the last evaluation |

## Verification
A corrupted recorded-value register does not show at once on `gpio_out`. It appears only as wrong or missing strobes one cycle after the next direction or level write. For that reason the bench checks the strobes after every such write, and not just the readback. A wrong direction or level bit shows on `gpio_out` and on the readback in the cycle after the write. Decode faults show on the very next read of the affected offset, or of any unmapped address.

// File: rtl/aux_gpio_pkg.sv
`timescale 1ns/1ps
package aux_gpio_pkg;
    localparam int unsigned REG_W = 16;
    localparam int unsigned WIN_W = 6;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_DETECT,
        SEL_STATUS,
        SEL_POWER,
        SEL_CTRL,
        SEL_IRAISE,
        SEL_IMASK,
        SEL_ISTAT,
        SEL_DIR,
        SEL_WLVL,
        SEL_RLVL
    } reg_sel_e;

    localparam logic [WIN_W-1:0] OFF_MODE   = 6'h00;
    localparam logic [WIN_W-1:0] OFF_DETECT = 6'h04;
    localparam logic [WIN_W-1:0] OFF_STATUS = 6'h08;
    localparam logic [WIN_W-1:0] OFF_POWER  = 6'h0C;
    localparam logic [WIN_W-1:0] OFF_CTRL   = 6'h10;
    localparam logic [WIN_W-1:0] OFF_IRAISE = 6'h14;
    localparam logic [WIN_W-1:0] OFF_IMASK  = 6'h18;
    localparam logic [WIN_W-1:0] OFF_ISTAT  = 6'h1C;
    localparam logic [WIN_W-1:0] OFF_DIR    = 6'h20;
    localparam logic [WIN_W-1:0] OFF_WLVL   = 6'h24;
    localparam logic [WIN_W-1:0] OFF_RLVL   = 6'h28;

    localparam logic [REG_W-1:0] STATUS_RST  = 16'h0002;
    localparam int unsigned      PWR_ARM_BIT = 7;
    localparam logic [REG_W-1:0] PWR_FORCE   = 16'h8040;

    localparam int unsigned N_PLAIN = 6;
endpackage

// File: rtl/aux_gpio_decode.sv
`timescale 1ns/1ps
module aux_gpio_decode
    import aux_gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    logic in_window;

    generate
        if (ADDR_W > WIN_W) begin : g_upper
            assign in_window = (addr[ADDR_W-1:WIN_W] == '0);
        end else begin : g_flat
            assign in_window = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        if (in_window) begin
            unique case (addr[WIN_W-1:0])
                OFF_MODE:   sel = SEL_MODE;
                OFF_DETECT: sel = SEL_DETECT;
                OFF_STATUS: sel = SEL_STATUS;
                OFF_POWER:  sel = SEL_POWER;
                OFF_CTRL:   sel = SEL_CTRL;
                OFF_IRAISE: sel = SEL_IRAISE;
                OFF_IMASK:  sel = SEL_IMASK;
                OFF_ISTAT:  sel = SEL_ISTAT;
                OFF_DIR:    sel = SEL_DIR;
                OFF_WLVL:   sel = SEL_WLVL;
                OFF_RLVL:   sel = SEL_RLVL;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/aux_gpio_ctrlregs.sv
`timescale 1ns/1ps
module aux_gpio_ctrlregs
    import aux_gpio_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  reg_sel_e                   sel,
    input  logic [REG_W-1:0]           wdata,
    output logic [N_PLAIN*REG_W-1:0]   plain_flat,
    output logic [REG_W-1:0]           power_q
);
    // Index i of plain_flat belongs to the selector returned here.
    function automatic reg_sel_e plain_sel(input int idx);
        case (idx)
            0:       return SEL_MODE;
            1:       return SEL_DETECT;
            2:       return SEL_CTRL;
            3:       return SEL_IRAISE;
            4:       return SEL_IMASK;
            default: return SEL_ISTAT;
        endcase
    endfunction

    generate
        for (genvar i = 0; i < N_PLAIN; i++) begin : g_plain
            logic [REG_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && (sel == plain_sel(i))) begin
                    word_q <= wdata;
                end
            end
            assign plain_flat[i*REG_W +: REG_W] = word_q;
        end
    endgenerate

    logic [REG_W-1:0] power_nx;
    always_comb begin
        power_nx = wdata;
        if (wdata[PWR_ARM_BIT]) begin
            power_nx = wdata | PWR_FORCE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            power_q <= '0;
        end else if (wr_en && (sel == SEL_POWER)) begin
            power_q <= power_nx;
        end
    end
endmodule

// File: rtl/aux_gpio_bank.sv
`timescale 1ns/1ps
module aux_gpio_bank
    import aux_gpio_pkg::*;
#(
    parameter int NLINE = REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dir,
    input  logic             wr_lvl,
    input  logic [NLINE-1:0] wdata,
    input  logic [NLINE-1:0] gpio_in,
    output logic [NLINE-1:0] dir_q,
    output logic [NLINE-1:0] lvl_q,
    output logic [NLINE-1:0] gpio_out,
    output logic [NLINE-1:0] gpio_chg,
    output logic [NLINE-1:0] gpio_chg_val
);
    logic [NLINE-1:0] in_q;
    logic [NLINE-1:0] dir_nx;
    logic [NLINE-1:0] lvl_nx;
    logic [NLINE-1:0] drive_nx;
    logic [NLINE-1:0] prev_q;
    logic             eval;

    assign eval   = wr_dir | wr_lvl;
    assign dir_nx = wr_dir ? wdata : dir_q;

    generate
        for (genvar b = 0; b < NLINE; b++) begin : g_line
            logic edge_b;
            logic base_b;
            assign edge_b    = gpio_in[b] ^ in_q[b];
            assign base_b    = wr_lvl ? (wdata[b] & dir_q[b]) : lvl_q[b];
            assign lvl_nx[b] = edge_b ? gpio_in[b] : base_b;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    in_q[b]  <= 1'b0;
                    lvl_q[b] <= 1'b0;
                    dir_q[b] <= 1'b0;
                end else begin
                    in_q[b]  <= gpio_in[b];
                    lvl_q[b] <= lvl_nx[b];
                    dir_q[b] <= dir_nx[b];
                end
            end
        end
    endgenerate

    assign drive_nx = lvl_nx & dir_nx;
    assign gpio_out = lvl_q & dir_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q       <= '0;
            gpio_chg     <= '0;
            gpio_chg_val <= '0;
        end else if (eval) begin
            prev_q       <= drive_nx;
            gpio_chg     <= prev_q ^ drive_nx;
            gpio_chg_val <= drive_nx;
        end else begin
            gpio_chg     <= '0;
        end
    end
endmodule

// File: rtl/aux_gpio_ctrl.sv
`timescale 1ns/1ps
module aux_gpio_ctrl
    import aux_gpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [REG_W-1:0]  gpio_in,
    output logic [REG_W-1:0]  gpio_out,
    output logic [REG_W-1:0]  gpio_chg,
    output logic [REG_W-1:0]  gpio_chg_val
);
    reg_sel_e                 sel;
    logic [N_PLAIN*REG_W-1:0] plain_flat;
    logic [REG_W-1:0]         power_q;
    logic [REG_W-1:0]         dir_q;
    logic [REG_W-1:0]         lvl_q;
    logic                     wr_dir;
    logic                     wr_lvl;

    aux_gpio_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    aux_gpio_ctrlregs u_ctrlregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we),
        .sel        (sel),
        .wdata      (bus_wdata),
        .plain_flat (plain_flat),
        .power_q    (power_q)
    );

    assign wr_dir = bus_we && (sel == SEL_DIR);
    assign wr_lvl = bus_we && ((sel == SEL_WLVL) || (sel == SEL_RLVL));

    aux_gpio_bank #(.NLINE(REG_W)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_dir       (wr_dir),
        .wr_lvl       (wr_lvl),
        .wdata        (bus_wdata),
        .gpio_in      (gpio_in),
        .dir_q        (dir_q),
        .lvl_q        (lvl_q),
        .gpio_out     (gpio_out),
        .gpio_chg     (gpio_chg),
        .gpio_chg_val (gpio_chg_val)
    );

    always_comb begin
        unique case (sel)
            SEL_MODE:   bus_rdata = plain_flat[0*REG_W +: REG_W];
            SEL_DETECT: bus_rdata = plain_flat[1*REG_W +: REG_W];
            SEL_STATUS: bus_rdata = STATUS_RST;
            SEL_POWER:  bus_rdata = power_q;
            SEL_CTRL:   bus_rdata = plain_flat[2*REG_W +: REG_W];
            SEL_IRAISE: bus_rdata = plain_flat[3*REG_W +: REG_W];
            SEL_IMASK:  bus_rdata = plain_flat[4*REG_W +: REG_W];
            SEL_ISTAT:  bus_rdata = plain_flat[5*REG_W +: REG_W];
            SEL_DIR:    bus_rdata = dir_q;
            SEL_WLVL,
            SEL_RLVL:   bus_rdata = lvl_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aux_gpio_ctrl_chk.sv
`timescale 1ns/1ps
module aux_gpio_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [15:0]       gpio_out,
    input logic [15:0]       gpio_chg,
    input logic [15:0]       gpio_chg_val,
    input logic [15:0]       power_q
);
    logic mapped;
    logic gpio_wr;
    assign mapped  = (bus_addr[1:0] == 2'b00) && (bus_addr <= ADDR_W'('h28));
    assign gpio_wr = bus_we && ((bus_addr == ADDR_W'('h20)) ||
                                (bus_addr == ADDR_W'('h24)) ||
                                (bus_addr == ADDR_W'('h28)));

    assert_status_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h08)) |-> (bus_rdata == 16'h0002));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 16'h0000));

    assert_out_within_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h20)) |-> ((gpio_out & ~bus_rdata) == 16'h0000));

    assert_chg_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_chg != 16'h0000) |-> $past(gpio_wr));

    assert_chg_val_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_chg != 16'h0000) |-> (gpio_chg_val == gpio_out));

    assert_power_force_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (bus_addr == ADDR_W'('h0C)) && bus_wdata[7])
            |-> (power_q[15] && power_q[6]));
endmodule

bind aux_gpio_ctrl aux_gpio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .gpio_out     (gpio_out),
    .gpio_chg     (gpio_chg),
    .gpio_chg_val (gpio_chg_val),
    .power_q      (power_q)
);

// File: tb/aux_gpio_ctrl_bench.sv
`timescale 1ns/1ps
module aux_gpio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;
    logic [15:0] gpio_chg;
    logic [15:0] gpio_chg_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_mode = '0, m_det = '0, m_pwr = '0, m_ctl = '0;
    logic [15:0] m_irs = '0, m_imk = '0, m_ist = '0;
    logic [15:0] m_dir = '0, m_lvl = '0, m_prev = '0, m_in = '0;

    always #5 clk = ~clk;

    aux_gpio_ctrl #(.ADDR_W(12)) u_aux_gpio_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .gpio_in      (gpio_in),
        .gpio_out     (gpio_out),
        .gpio_chg     (gpio_chg),
        .gpio_chg_val (gpio_chg_val)
    );

    function automatic logic [15:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_mode;
            12'h004: return m_det;
            12'h008: return 16'h0002;
            12'h00C: return m_pwr;
            12'h010: return m_ctl;
            12'h014: return m_irs;
            12'h018: return m_imk;
            12'h01C: return m_ist;
            12'h020: return m_dir;
            12'h024, 12'h028: return m_lvl;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic bit is_mapped(input logic [11:0] a);
        return (a[1:0] == 2'b00) && (a <= 12'h028);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic [15:0] in_v);
        logic        trig;
        logic [15:0] edges, newo, expc;
        trig = 1'b0;
        newo = '0;
        case (a)
            12'h000: m_mode = d;
            12'h004: m_det = d;
            12'h00C: m_pwr = d[7] ? (d | 16'h8040) : d;
            12'h010: m_ctl = d;
            12'h014: m_irs = d;
            12'h018: m_imk = d;
            12'h01C: m_ist = d;
            12'h020: begin m_dir = d; trig = 1'b1; end
            12'h024, 12'h028: begin m_lvl = d & m_dir; trig = 1'b1; end
            default: ;
        endcase
        edges = in_v ^ m_in;
        m_lvl = (m_lvl & ~edges) | (in_v & edges);
        m_in  = in_v;
        if (trig) begin
            newo   = m_lvl & m_dir;
            expc   = m_prev ^ newo;
            m_prev = newo;
        end else begin
            expc = '0;
        end
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        gpio_in   = in_v;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        check("R7 strobe", gpio_chg, expc);
        if (expc != 16'h0000) check("R7 value", gpio_chg_val, newo);
        check("R6 out", gpio_out, m_lvl & m_dir);
        @(negedge clk);
        #1;
        check("R7 single pulse", gpio_chg, 16'h0000);
    endtask

    task automatic set_in(input logic [15:0] v);
        logic [15:0] edges;
        edges = v ^ m_in;
        m_lvl = (m_lvl & ~edges) | (v & edges);
        m_in  = v;
        @(negedge clk);
        gpio_in = v;
        @(negedge clk);
        #1;
        check("R8 no strobe", gpio_chg, 16'h0000);
        check("R8 out", gpio_out, m_lvl & m_dir);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned x;
        logic [11:0] plain_off [6];
        plain_off = '{12'h000, 12'h004, 12'h010, 12'h014, 12'h018, 12'h01C};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 out", gpio_out, 16'h0000);
        check("R1 chg", gpio_chg, 16'h0000);
        check("R1 chg_val", gpio_chg_val, 16'h0000);
        for (int a = 0; a <= 'h28; a += 4) rd(12'(a), "R1 reset read");

        // R2 plain storage words
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < 8; k++) begin
                wr(plain_off[r], 16'(k * 16'h1357) ^ 16'(r << 12) ^ 16'hA5C3, m_in);
                rd(plain_off[r], "R2 readback");
            end
        end
        for (int r = 0; r < 6; r++) rd(plain_off[r], "R2 retained");

        // R3 power word, every low byte
        for (int v = 0; v < 256; v++) begin
            wr(12'h00C, {8'(v * 37), 8'(v)}, m_in);
            rd(12'h00C, "R3 power");
        end

        // R4 status read-only
        wr(12'h008, 16'hFFFF, m_in);
        rd(12'h008, "R4 status");
        wr(12'h008, 16'h0000, m_in);
        rd(12'h008, "R4 status");

        // R5 masking corners
        wr(12'h020, 16'h0000, m_in);
        wr(12'h024, 16'hFFFF, m_in);
        rd(12'h024, "R5 masked by zero dir");
        wr(12'h020, 16'h00FF, m_in);
        wr(12'h028, 16'hFFFF, m_in);
        rd(12'h028, "R5 level via 0x28");
        rd(12'h024, "R5 level via 0x24");
        wr(12'h020, 16'h0F0F, m_in);
        rd(12'h020, "R5 dir");

        // R5/R6/R7 sweep
        x = 32'h1234_5678;
        for (int i = 0; i < 120; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            if (i % 3 == 0) wr(12'h020, x[31:16], m_in);
            else if (i % 3 == 1) wr(12'h024, x[23:8], m_in);
            else wr(12'h028, x[15:0], m_in);
            rd(12'h020, "R5 dir sweep");
            rd(12'h024, "R5 level sweep 0x24");
            rd(12'h028, "R5 level sweep 0x28");
        end

        // R8 input edges
        wr(12'h020, 16'hFFFF, m_in);
        wr(12'h024, 16'h0000, m_in);
        for (int b = 0; b < 16; b++) begin
            set_in(m_in | 16'(1 << b));
            rd(12'h024, "R8 level after rise");
        end
        for (int b = 0; b < 16; b += 2) begin
            set_in(m_in & ~16'(1 << b));
            rd(12'h028, "R8 level after fall");
        end
        wr(12'h020, 16'hFFFF, m_in);
        wr(12'h020, 16'h3C3C, m_in);

        // R10 same-cycle conflict
        wr(12'h020, 16'hFFFF, m_in);
        wr(12'h024, 16'h0000, m_in ^ 16'h0101);
        rd(12'h024, "R10 input wins");
        wr(12'h028, 16'hFFFF, m_in ^ 16'h8001);
        rd(12'h028, "R10 input wins");
        wr(12'h020, 16'hF00F, m_in ^ 16'h00F0);
        rd(12'h024, "R10 with dir write");

        // R9 unmapped accesses
        for (int a = 0; a < 64; a++) begin
            if (!is_mapped(12'(a))) begin
                wr(12'(a), 16'hFFFF, m_in);
                rd(12'(a), "R9 unmapped read");
            end
        end
        wr(12'h040, 16'hFFFF, m_in);
        rd(12'h040, "R9 unmapped read");
        wr(12'h420, 16'h1234, m_in);
        rd(12'h420, "R9 alias read");
        wr(12'hFFC, 16'hFFFF, m_in);
        rd(12'hFFC, "R9 unmapped read");
        for (int a = 0; a <= 'h28; a += 4) rd(12'(a), "R9 mapped untouched");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule